// File: doc/BRIEF.md
# Routed Shared Interrupt Distributor

This block collects a parameterized set of shared peripheral interrupt lines and spreads them across a small, parameterized group of processing elements (PEs). Every source keeps its own configuration: a priority byte, an interrupt group, a trigger mode (edge or level), a routing word and an enable bit. The block also tracks a pending flag and an active flag for each source. The configuration is reached through a register port with a field select and a source index. Enables are changed only through separate set and clear vectors.

For every PE the block offers the best eligible interrupt, as an ID and a priority, on a valid/ready channel. Ready is the PE's acknowledge: when valid and ready are both high at a rising edge, the offered source becomes active. The offer is a live view and not a queue. While ready is low, the offer may change to a better interrupt, or be withdrawn if the interrupt becomes ineligible. Only the ID presented in the handshake cycle is acknowledged. A separate deactivate strobe carrying an ID ends the active state.

A source is routed in one of two ways. In directed mode it goes to one named PE. In any-of-N mode the hardware picks a PE, and each PE can exclude itself from any-of-N delivery for each group separately. A PE accepts an interrupt only if the interrupt's priority value is strictly below both the PE's priority mask and the PE's running priority.

Top module: `irq_dist`

## Requirements
- R1: After reset every source has priority 0, group 0, level trigger, directed routing to PE 0, and enable, pending and active all 0. No PE sees valid.
- R2: On `en_set`/`en_clr`, only bits at 1 act. A set bit enables its source and a clear bit disables it. When both are 1 for one source, clear wins. Zero bits leave the enable unchanged.
- R3: A level-triggered source has pending equal to its input line as sampled at the previous rising edge. It is pending while the line is high and not pending once the line is low.
- R4: An edge-triggered source becomes pending one edge after its line goes from 0 to 1. It stays pending after the line drops, until it is acknowledged.
- R5: A source is offered only if it is pending, not active, enabled, and its group is enabled in `grp_en` (bit g for group g = 0, 1, 2). Group value 3 is never offered.
- R6: A PE is offered an interrupt only if the priority value is strictly less than both that PE's `pe_pmr` byte and its `pe_rpr` byte.
- R7: A route word with bit 7 = 0 sends the source only to the PE whose index is held in route bits [PE_W-1:0].
- R8: A route word with bit 7 = 1 sends the source to the lowest-numbered PE that passes R6 and has not opted out. PE p opts out of group g when `pe_optout[p*3+g]` is 1.
- R9: Among the sources offered to one PE, the lowest priority value wins, and ties go to the lower source ID. The result is shown on `pe_id`/`pe_prio` with `pe_valid` high.
- R10: A valid&ready handshake on PE p at a rising edge sets active for the offered ID. An edge source loses pending. A level source whose line is still high remains pending, so it becomes active and pending. An active source is not offered.
- R11: `deact_valid` with `deact_id` clears that source's active flag at the next edge.
- R12: Field select codes for `cfg_sel`:
  - 0: priority (8 bits).
  - 1: group (data bits [1:0]).
  - 2: trigger (bit 0, 1 = edge).
  - 3: route (bit 7 = any-of-N, low bits = PE index).
  - 4: read-only status (bit 0 pending, bit 1 active, bit 2 enable).

  Writes to code 4 and to unused codes change nothing, and unused codes read 0. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_SRC | Interrupt lines, one per source |
| grp_en | input | 3 | Global enable per group |
| en_set | input | N_SRC | Set-enable strobes |
| en_clr | input | N_SRC | Clear-enable strobes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Field select |
| cfg_idx | input | ID_W | Source index |
| cfg_wdata | input | PRIO_W | Write data |
| cfg_rdata | output | PRIO_W | Read data for the selected field and source |
| pe_pmr | input | N_PE*PRIO_W | Priority mask per PE |
| pe_rpr | input | N_PE*PRIO_W | Running priority per PE |
| pe_optout | input | N_PE*3 | Any-of-N opt-out per PE and group |
| pe_valid | output | N_PE | Interrupt offered to each PE |
| pe_ready | input | N_PE | Acknowledge from each PE |
| pe_id | output | N_PE*ID_W | Offered source ID per PE |
| pe_prio | output | N_PE*PRIO_W | Offered priority per PE |
| deact_valid | input | 1 | Deactivate strobe |
| deact_id | input | ID_W | Source to deactivate |

## Verification
The properties assume the following about the inputs:
- A deactivate names a source that is active.
- A deactivate never names the source being acknowledged in the same cycle.
- A PE raises ready only while it sees valid.
- Configuration and masks change on falling edges, never across a handshake.

The directed stimulus respects all of these. It drives every input on the falling edge. It raises ready or a deactivate for exactly one cycle, and only after checking that the intended source is offered or active.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  typedef enum logic [2:0] {
    SEL_PRIO   = 3'd0,
    SEL_GROUP  = 3'd1,
    SEL_TRIG   = 3'd2,
    SEL_ROUTE  = 3'd3,
    SEL_STATUS = 3'd4
  } cfg_sel_e;

  localparam int unsigned GRP_NUM = 3;

  // pick the bit of a per-group vector for group g; group 3 selects nothing
  function automatic logic grp_pick(input logic [GRP_NUM-1:0] vec, input logic [1:0] g);
    case (g)
      2'd0:    return vec[0];
      2'd1:    return vec[1];
      2'd2:    return vec[2];
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/irq_dist_src.sv
module irq_dist_src #(
  parameter int PRIO_W = 8,
  parameter int PE_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq,
  input  logic              wr_prio,
  input  logic              wr_grp,
  input  logic              wr_trig,
  input  logic              wr_route,
  input  logic [PRIO_W-1:0] wdata,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic              ack,
  input  logic              deact,
  output logic [PRIO_W-1:0] prio,
  output logic [1:0]        grp,
  output logic              edge_mode,
  output logic              route_any,
  output logic [PE_W-1:0]   route_tgt,
  output logic              enable,
  output logic              pending,
  output logic              active
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q     <= 1'b0;
      prio      <= '0;
      grp       <= '0;
      edge_mode <= 1'b0;
      route_any <= 1'b0;
      route_tgt <= '0;
      enable    <= 1'b0;
      pending   <= 1'b0;
      active    <= 1'b0;
    end else begin
      irq_q <= irq;
      if (wr_prio)  prio      <= wdata;
      if (wr_grp)   grp       <= wdata[1:0];
      if (wr_trig)  edge_mode <= wdata[0];
      if (wr_route) begin
        route_any <= wdata[PRIO_W-1];
        route_tgt <= wdata[PE_W-1:0];
      end
      if (en_clr)      enable <= 1'b0;
      else if (en_set) enable <= 1'b1;
      if (edge_mode) pending <= (pending & ~ack) | (irq & ~irq_q);
      else           pending <= irq;
      if (ack)        active <= 1'b1;
      else if (deact) active <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_dist_route.sv
module irq_dist_route
  import irq_dist_pkg::*;
#(
  parameter int N_PE   = 3,
  parameter int PRIO_W = 8,
  parameter int PE_W   = 2
) (
  input  logic [PRIO_W-1:0]  prio,
  input  logic [1:0]         grp,
  input  logic               route_any,
  input  logic [PE_W-1:0]    route_tgt,
  input  logic [PRIO_W-1:0]  pmr    [N_PE],
  input  logic [PRIO_W-1:0]  rpr    [N_PE],
  input  logic [GRP_NUM-1:0] optout [N_PE],
  output logic [N_PE-1:0]    tgt
);
  logic found;
  logic ok;

  always_comb begin
    tgt   = '0;
    found = 1'b0;
    ok    = 1'b0;
    for (int p = 0; p < N_PE; p++) begin
      ok = (prio < pmr[p]) && (prio < rpr[p]);
      if (!route_any) begin
        if (route_tgt == PE_W'(p) && ok) tgt[p] = 1'b1;
      end else if (!found && ok && !grp_pick(optout[p], grp)) begin
        tgt[p] = 1'b1;
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_dist_arb.sv
module irq_dist_arb #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 8,
  parameter int ID_W   = 3
) (
  input  logic [N_SRC-1:0]  cand,
  input  logic [PRIO_W-1:0] prio_all [N_SRC],
  output logic              valid,
  output logic [ID_W-1:0]   id,
  output logic [PRIO_W-1:0] prio_o
);
  // ascending scan with strict compare keeps the lowest ID on ties
  always_comb begin
    valid  = 1'b0;
    id     = '0;
    prio_o = '1;
    for (int s = 0; s < N_SRC; s++) begin
      if (cand[s] && (!valid || prio_all[s] < prio_o)) begin
        valid  = 1'b1;
        id     = ID_W'(s);
        prio_o = prio_all[s];
      end
    end
  end
endmodule

// File: rtl/irq_dist.sv
module irq_dist
  import irq_dist_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int N_PE   = 3,
  parameter int PRIO_W = 8,
  localparam int ID_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int PE_W  = (N_PE > 1) ? $clog2(N_PE) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_SRC-1:0]         irq_in,
  input  logic [GRP_NUM-1:0]       grp_en,
  input  logic [N_SRC-1:0]         en_set,
  input  logic [N_SRC-1:0]         en_clr,
  input  logic                     cfg_we,
  input  logic [2:0]               cfg_sel,
  input  logic [ID_W-1:0]          cfg_idx,
  input  logic [PRIO_W-1:0]        cfg_wdata,
  output logic [PRIO_W-1:0]        cfg_rdata,
  input  logic [N_PE*PRIO_W-1:0]   pe_pmr,
  input  logic [N_PE*PRIO_W-1:0]   pe_rpr,
  input  logic [N_PE*GRP_NUM-1:0]  pe_optout,
  output logic [N_PE-1:0]          pe_valid,
  input  logic [N_PE-1:0]          pe_ready,
  output logic [N_PE*ID_W-1:0]     pe_id,
  output logic [N_PE*PRIO_W-1:0]   pe_prio,
  input  logic                     deact_valid,
  input  logic [ID_W-1:0]          deact_id
);
  // per-source state
  logic [PRIO_W-1:0] prio_u  [N_SRC];
  logic [1:0]        grp_u   [N_SRC];
  logic [PE_W-1:0]   tgt_u   [N_SRC];
  logic [N_PE-1:0]   route_m [N_SRC];
  logic [N_SRC-1:0]  edge_v, any_v, en_v, pend_v, act_v, ack_v, deact_v;

  // per-PE view
  logic [PRIO_W-1:0]  pmr_u  [N_PE];
  logic [PRIO_W-1:0]  rpr_u  [N_PE];
  logic [GRP_NUM-1:0] opt_u  [N_PE];
  logic [N_SRC-1:0]   cand_m [N_PE];
  logic               arb_vld  [N_PE];
  logic [ID_W-1:0]    arb_id   [N_PE];
  logic [PRIO_W-1:0]  arb_prio [N_PE];

  always_comb begin
    for (int p = 0; p < N_PE; p++) begin
      pmr_u[p] = pe_pmr[p*PRIO_W +: PRIO_W];
      rpr_u[p] = pe_rpr[p*PRIO_W +: PRIO_W];
      opt_u[p] = pe_optout[p*GRP_NUM +: GRP_NUM];
    end
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    logic hit;
    assign hit = cfg_we && (cfg_idx == ID_W'(s));

    irq_dist_src #(.PRIO_W(PRIO_W), .PE_W(PE_W)) src_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq       (irq_in[s]),
      .wr_prio   (hit && cfg_sel == SEL_PRIO),
      .wr_grp    (hit && cfg_sel == SEL_GROUP),
      .wr_trig   (hit && cfg_sel == SEL_TRIG),
      .wr_route  (hit && cfg_sel == SEL_ROUTE),
      .wdata     (cfg_wdata),
      .en_set    (en_set[s]),
      .en_clr    (en_clr[s]),
      .ack       (ack_v[s]),
      .deact     (deact_v[s]),
      .prio      (prio_u[s]),
      .grp       (grp_u[s]),
      .edge_mode (edge_v[s]),
      .route_any (any_v[s]),
      .route_tgt (tgt_u[s]),
      .enable    (en_v[s]),
      .pending   (pend_v[s]),
      .active    (act_v[s])
    );

    irq_dist_route #(.N_PE(N_PE), .PRIO_W(PRIO_W), .PE_W(PE_W)) route_i (
      .prio      (prio_u[s]),
      .grp       (grp_u[s]),
      .route_any (any_v[s]),
      .route_tgt (tgt_u[s]),
      .pmr       (pmr_u),
      .rpr       (rpr_u),
      .optout    (opt_u),
      .tgt       (route_m[s])
    );

    assign deact_v[s] = deact_valid && (deact_id == ID_W'(s));
  end

  // eligibility per PE and source
  always_comb begin
    for (int p = 0; p < N_PE; p++) begin
      for (int s = 0; s < N_SRC; s++) begin
        cand_m[p][s] = pend_v[s] && !act_v[s] && en_v[s]
                     && grp_pick(grp_en, grp_u[s]) && route_m[s][p];
      end
    end
  end

  for (genvar p = 0; p < N_PE; p++) begin : g_pe
    irq_dist_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) arb_i (
      .cand     (cand_m[p]),
      .prio_all (prio_u),
      .valid    (arb_vld[p]),
      .id       (arb_id[p]),
      .prio_o   (arb_prio[p])
    );
  end

  always_comb begin
    for (int p = 0; p < N_PE; p++) begin
      pe_valid[p]                   = arb_vld[p];
      pe_id[p*ID_W +: ID_W]         = arb_id[p];
      pe_prio[p*PRIO_W +: PRIO_W]   = arb_prio[p];
    end
  end

  // acknowledge: handshake on the PE that holds the offer
  always_comb begin
    ack_v = '0;
    for (int p = 0; p < N_PE; p++) begin
      for (int s = 0; s < N_SRC; s++) begin
        if (arb_vld[p] && pe_ready[p] && arb_id[p] == ID_W'(s)) ack_v[s] = 1'b1;
      end
    end
  end

  // configuration read
  always_comb begin
    cfg_rdata = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (cfg_idx == ID_W'(s)) begin
        case (cfg_sel)
          SEL_PRIO:   cfg_rdata = prio_u[s];
          SEL_GROUP:  cfg_rdata = PRIO_W'(grp_u[s]);
          SEL_TRIG:   cfg_rdata = PRIO_W'(edge_v[s]);
          SEL_ROUTE:  cfg_rdata = {any_v[s], (PRIO_W-1)'(tgt_u[s])};
          SEL_STATUS: cfg_rdata = PRIO_W'({en_v[s], act_v[s], pend_v[s]});
          default:    cfg_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_dist_chk.sv
module irq_dist_chk #(
  parameter int N_SRC  = 8,
  parameter int N_PE   = 3,
  parameter int PRIO_W = 8,
  parameter int ID_W   = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_PE*PRIO_W-1:0] pe_pmr,
  input logic [N_PE*PRIO_W-1:0] pe_rpr,
  input logic [N_PE-1:0]        pe_valid,
  input logic [N_PE*ID_W-1:0]   pe_id,
  input logic [N_PE*PRIO_W-1:0] pe_prio,
  input logic                   deact_valid,
  input logic [ID_W-1:0]        deact_id,
  input logic [N_SRC-1:0]       en_clr,
  input logic [N_SRC-1:0]       edge_v,
  input logic [N_SRC-1:0]       en_v,
  input logic [N_SRC-1:0]       pend_v,
  input logic [N_SRC-1:0]       act_v,
  input logic [N_SRC-1:0]       ack_v
);
  for (genvar p = 0; p < N_PE; p++) begin : g_pe
    // R6: offered priority beats both mask and running priority
    a_r6_mask: assert property (@(posedge clk) disable iff (!rst_n)
      pe_valid[p] |-> (pe_prio[p*PRIO_W +: PRIO_W] < pe_pmr[p*PRIO_W +: PRIO_W]) &&
                      (pe_prio[p*PRIO_W +: PRIO_W] < pe_rpr[p*PRIO_W +: PRIO_W]));
    // R5: offered source is pending, enabled and not active
    a_r5_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      pe_valid[p] |-> en_v[pe_id[p*ID_W +: ID_W]] && pend_v[pe_id[p*ID_W +: ID_W]]
                      && !act_v[pe_id[p*ID_W +: ID_W]]);
    for (genvar q = p + 1; q < N_PE; q++) begin : g_pair
      // R8: a source is never offered to two PEs at once
      a_r8_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_valid[p] && pe_valid[q]) |-> (pe_id[p*ID_W +: ID_W] != pe_id[q*ID_W +: ID_W]));
    end
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    // R10: handshake makes the source active
    a_r10_ack_active: assert property (@(posedge clk) disable iff (!rst_n)
      ack_v[s] |=> act_v[s]);
    // R11: deactivate clears active
    a_r11_deact: assert property (@(posedge clk) disable iff (!rst_n)
      (deact_valid && deact_id == ID_W'(s) && !ack_v[s]) |=> !act_v[s]);
    // R2: clear strobe leaves the source disabled
    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
      en_clr[s] |=> !en_v[s]);
    // R4: edge pending holds until acknowledged
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_v[s] && pend_v[s] && !ack_v[s]) |=> (pend_v[s] || !edge_v[s]));
  end
endmodule

bind irq_dist irq_dist_chk #(
  .N_SRC(N_SRC), .N_PE(N_PE), .PRIO_W(PRIO_W), .ID_W(ID_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .pe_pmr      (pe_pmr),
  .pe_rpr      (pe_rpr),
  .pe_valid    (pe_valid),
  .pe_id       (pe_id),
  .pe_prio     (pe_prio),
  .deact_valid (deact_valid),
  .deact_id    (deact_id),
  .en_clr      (en_clr),
  .edge_v      (edge_v),
  .en_v        (en_v),
  .pend_v      (pend_v),
  .act_v       (act_v),
  .ack_v       (ack_v)
);

// File: tb/irq_dist_tb.sv
module irq_dist_tb_top;
  localparam int NS = 8;
  localparam int NP = 3;
  localparam int PW = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] irq_in = '0;
  logic [2:0]    grp_en = 3'b111;
  logic [NS-1:0] en_set = '0, en_clr = '0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [IW-1:0] cfg_idx = '0;
  logic [PW-1:0] cfg_wdata = '0;
  logic [PW-1:0] cfg_rdata;
  logic [NP*PW-1:0] pe_pmr = '1, pe_rpr = '1;
  logic [NP*3-1:0]  pe_optout = '0;
  logic [NP-1:0]    pe_valid;
  logic [NP-1:0]    pe_ready = '0;
  logic [NP*IW-1:0] pe_id;
  logic [NP*PW-1:0] pe_prio;
  logic             deact_valid = 1'b0;
  logic [IW-1:0]    deact_id = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_dist #(.N_SRC(NS), .N_PE(NP), .PRIO_W(PW)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic check_pe(input int p, input bit ev, input int eid, input int eprio, input string req);
    chk(pe_valid[p] == ev, req, $sformatf("pe%0d valid", p), pe_valid[p], ev);
    if (ev) begin
      chk(pe_id[p*IW +: IW] == eid, req, $sformatf("pe%0d id", p), pe_id[p*IW +: IW], eid);
      chk(pe_prio[p*PW +: PW] == eprio, req, $sformatf("pe%0d prio", p), pe_prio[p*PW +: PW], eprio);
    end
  endtask

  task automatic cfg_wr(input int sel, input int idx, input int data);
    cfg_sel = 3'(sel); cfg_idx = IW'(idx); cfg_wdata = PW'(data); cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input int sel, input int idx, output int data);
    cfg_sel = 3'(sel); cfg_idx = IW'(idx);
    #1;
    data = int'(cfg_rdata);
  endtask

  task automatic check_status(input int idx, input int exp, input string req);
    int v;
    cfg_rd(4, idx, v);
    chk(v == exp, req, $sformatf("status src%0d", idx), v, exp);
  endtask

  task automatic enable(input logic [NS-1:0] m);
    en_set = m; step(); en_set = '0;
  endtask

  task automatic pulse(input logic [NS-1:0] m);
    irq_in = irq_in | m; step(); irq_in = irq_in & ~m;
  endtask

  task automatic ack(input int p);
    pe_ready[p] = 1'b1; step(); pe_ready[p] = 1'b0;
  endtask

  task automatic deact(input int id);
    deact_id = IW'(id); deact_valid = 1'b1; step(); deact_valid = 1'b0;
  endtask

  task automatic t_reset();
    int v;
    for (int p = 0; p < NP; p++) check_pe(p, 1'b0, 0, 0, "R1");
    for (int s = 0; s < NS; s++) check_status(s, 0, "R1");
    cfg_rd(0, 5, v); chk(v == 0, "R1", "prio", v, 0);
    cfg_rd(3, 5, v); chk(v == 0, "R1", "route", v, 0);
    cfg_rd(2, 5, v); chk(v == 0, "R1", "trig", v, 0);
  endtask

  task automatic t_cfg();
    int v;
    cfg_wr(0, 6, 8'hA5); cfg_rd(0, 6, v); chk(v == 8'hA5, "R12", "prio rb", v, 8'hA5);
    cfg_wr(1, 6, 2);     cfg_rd(1, 6, v); chk(v == 2, "R12", "group rb", v, 2);
    cfg_wr(2, 6, 1);     cfg_rd(2, 6, v); chk(v == 1, "R12", "trig rb", v, 1);
    cfg_wr(3, 6, 8'h82); cfg_rd(3, 6, v); chk(v == 8'h82, "R12", "route rb", v, 8'h82);
    cfg_wr(4, 6, 8'hFF); check_status(6, 0, "R12");
    cfg_wr(5, 6, 8'hFF); cfg_rd(5, 6, v); chk(v == 0, "R12", "unused sel", v, 0);
    cfg_rd(0, 5, v); chk(v == 0, "R12", "other src untouched", v, 0);
    cfg_wr(1, 6, 0); cfg_wr(3, 6, 0);
  endtask

  task automatic t_enable();
    enable(8'h28);
    check_status(3, 4, "R2"); check_status(5, 4, "R2"); check_status(4, 0, "R2");
    en_set = 8'h20; en_clr = 8'h20; step(); en_set = '0; en_clr = '0;
    check_status(5, 0, "R2 clear wins");
    en_clr = 8'h00; step();
    check_status(3, 4, "R2 zero ignored");
    en_clr = 8'h08; step(); en_clr = '0;
    check_status(3, 0, "R2 clear");
  endtask

  task automatic t_level();
    cfg_wr(0, 1, 8'h10); enable(8'h02);
    irq_in[1] = 1'b1; step();
    check_status(1, 5, "R3");
    check_pe(0, 1'b1, 1, 8'h10, "R7"); check_pe(1, 1'b0, 0, 0, "R7");
    irq_in[1] = 1'b0; step();
    check_status(1, 4, "R3");
    check_pe(0, 1'b0, 0, 0, "R3");
  endtask

  task automatic t_edge();
    cfg_wr(2, 2, 1); cfg_wr(0, 2, 8'h20); cfg_wr(3, 2, 8'h01); enable(8'h04);
    pulse(8'h04); step();
    check_status(2, 5, "R4");
    check_pe(1, 1'b1, 2, 8'h20, "R7"); check_pe(0, 1'b0, 0, 0, "R7");
    ack(1);
    check_status(2, 6, "R10"); check_pe(1, 1'b0, 0, 0, "R10");
    deact(2);
    check_status(2, 4, "R11");
  endtask

  task automatic t_gate();
    pulse(8'h04);
    check_pe(1, 1'b1, 2, 8'h20, "R5");
    grp_en = 3'b110; step(); check_pe(1, 1'b0, 0, 0, "R5 group off");
    grp_en = 3'b111; en_clr = 8'h04; step(); en_clr = '0;
    check_pe(1, 1'b0, 0, 0, "R5 disabled"); check_status(2, 1, "R5");
    enable(8'h04); check_pe(1, 1'b1, 2, 8'h20, "R5");
    cfg_wr(1, 2, 3); check_pe(1, 1'b0, 0, 0, "R5 group3");
    cfg_wr(1, 2, 2); check_pe(1, 1'b1, 2, 8'h20, "R5 group2");
    cfg_wr(1, 2, 0);
  endtask

  task automatic t_prio();
    pe_pmr[PW +: PW] = 8'h20; step(); check_pe(1, 1'b0, 0, 0, "R6 mask equal");
    pe_pmr[PW +: PW] = 8'h21; step(); check_pe(1, 1'b1, 2, 8'h20, "R6 mask above");
    pe_rpr[PW +: PW] = 8'h20; step(); check_pe(1, 1'b0, 0, 0, "R6 running");
    pe_pmr = '1; pe_rpr = '1; step();
    ack(1); deact(2); check_status(2, 4, "R11");
  endtask

  task automatic t_any();
    cfg_wr(2, 3, 1); cfg_wr(1, 3, 1); cfg_wr(0, 3, 8'h40); cfg_wr(3, 3, 8'h80);
    enable(8'h08); pulse(8'h08);
    check_pe(0, 1'b1, 3, 8'h40, "R8"); check_pe(1, 1'b0, 0, 0, "R8"); check_pe(2, 1'b0, 0, 0, "R8");
    pe_optout = 9'h002; step();
    check_pe(0, 1'b0, 0, 0, "R8 optout"); check_pe(1, 1'b1, 3, 8'h40, "R8 optout");
    pe_pmr[PW +: PW] = 8'h40; step();
    check_pe(1, 1'b0, 0, 0, "R8 mask"); check_pe(2, 1'b1, 3, 8'h40, "R8 mask");
    pe_optout = 9'h082; step();
    for (int p = 0; p < NP; p++) check_pe(p, 1'b0, 0, 0, "R8 all out");
    pe_optout = 9'h081; step();
    check_pe(0, 1'b1, 3, 8'h40, "R8 other group");
    pe_optout = '0; pe_pmr = '1; step();
    ack(0); deact(3); check_status(3, 4, "R11");
  endtask

  task automatic t_arb();
    for (int s = 4; s < 8; s++) begin
      cfg_wr(2, s, 1); cfg_wr(3, s, 0);
    end
    cfg_wr(0, 4, 8'h30); cfg_wr(0, 5, 8'h30); cfg_wr(0, 6, 8'h50); cfg_wr(0, 7, 8'h05);
    enable(8'hF0); pulse(8'hF0);
    check_pe(0, 1'b1, 7, 8'h05, "R9 lowest value");
    ack(0); check_pe(0, 1'b1, 4, 8'h30, "R9 tie low id");
    ack(0); check_pe(0, 1'b1, 5, 8'h30, "R9");
    ack(0); check_pe(0, 1'b1, 6, 8'h50, "R9");
    ack(0); check_pe(0, 1'b0, 0, 0, "R10 all active");
    for (int s = 4; s < 8; s++) begin
      deact(s); check_status(s, 4, "R11");
    end
  endtask

  task automatic t_level_ack();
    irq_in[1] = 1'b1; step();
    check_pe(0, 1'b1, 1, 8'h10, "R3");
    ack(0);
    check_status(1, 7, "R10 active and pending"); check_pe(0, 1'b0, 0, 0, "R10");
    irq_in[1] = 1'b0; step();
    check_status(1, 6, "R3");
    deact(1); check_status(1, 4, "R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_cfg();
    t_enable();
    t_level();
    t_edge();
    t_gate();
    t_prio();
    t_any();
    t_arb();
    t_level_ack();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule